// File: doc/BRIEF.md
# Tape Record Byte-to-Word Assembler

This block takes one tape record from a formatter, delivered as a stream of 8-bit bytes over a ready/acknowledge handshake, and turns it into 36-bit words in memory. Each group of five bytes forms one word. Four whole bytes fill the upper 32 bits and the low nibble of the fifth byte fills the bottom 4 bits. Bytes and formatter status reach the block inverted, so the block complements them before using them. Finished words leave through a valid/ready write port. The first word goes to a start address given by the host, and each later word goes to the next address. Words are stored only up to a host-given word limit.

A record has no explicit end marker. The block treats a silence on the byte-ready line that lasts a programmable number of cycles as the end. It then waits until the formatter reports that it is no longer busy and reads the status flags to decide how the record ended. The host gets a single done pulse carrying two things:
- a 36-bit result, which is either the next free address or a fixed code for end of file or for error;
- a flag saying that the record held more complete words than the limit allowed.

Top module: `tape_word_packer`

## Requirements
- R1: A stored word holds its five bytes in arrival order. The first byte occupies bits 35:28, the second 27:20, the third 19:12 and the fourth 11:4. Bits 3:0 come from bits 3:0 of the fifth byte.
- R2: `byte_data_n` carries the complement of the byte value, and the stored word uses the complemented (true) value. `fmt_status_n` is also active-low: bit 0 busy, bit 1 error, bit 2 overrun, bit 3 end of file.
- R3: While a record is being received, `byte_ack` goes high the cycle after `byte_rdy` is sampled high. It stays high until `byte_rdy` is sampled low and then drops. Each such handshake consumes exactly one byte.
- R4: The record ends once `TO_CYCLES` consecutive receive cycles pass with no byte ready. This counter restarts on every accepted byte, so gaps shorter than the limit never end a record.
- R5: At most `word_limit` words are written. Any complete word beyond the limit is consumed but not written, and `too_long` is set. A limit of zero writes nothing.
- R6: If the record ends with fewer than five bytes pending in a partial word, those bytes are discarded and never written.
- R7: Words are written through `mem_wr_valid`/`mem_wr_ready`. The first address is `base_addr` and each accepted write advances the address by one, wrapping at the address width. While a write is stalled, the address and data stay stable.
- R8: After the end-of-record timeout, no result is given while the busy status is active.
- R9: Once the formatter is not busy, the result is chosen in priority order:
  - if error or overrun is set, the result is octal 50 in bits 35:30 with zeros below;
  - otherwise, if end of file is set, it is octal 60 in bits 35:30 with zeros below;
  - otherwise it is the next free address, zero-extended.
- R10: `done` is a one-cycle pulse. `result` and `too_long` are valid in that cycle, and `start` clears `too_long` for the new record.
- R11: When no record is active, `byte_rdy` is ignored: no acknowledge is given and nothing is written.
- R12: After reset, `byte_ack`, `mem_wr_valid`, `done`, `too_long` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin receiving a record (one-cycle pulse, used while idle) |
| base_addr | input | ADDR_W | Address of the first stored word |
| word_limit | input | CNT_W | Largest number of words to store |
| byte_rdy | input | 1 | Formatter has a byte available |
| byte_data_n | input | 8 | Complemented byte value |
| byte_ack | output | 1 | Byte acknowledge to formatter |
| fmt_status_n | input | 4 | Complemented status: busy, error, overrun, end of file |
| mem_wr_valid | output | 1 | Word write request |
| mem_wr_ready | input | 1 | Memory accepts the write |
| mem_wr_addr | output | ADDR_W | Write address |
| mem_wr_data | output | 36 | Assembled word |
| done | output | 1 | Record finished (pulse) |
| result | output | 36 | Next address or end code |
| too_long | output | 1 | Record exceeded the word limit |

## Verification
The bench targets four kinds of mistake, each with a clear symptom:
- A partial trailing word. A design that flushes a partial trailing word shows up as an extra write.
- A limit of zero and the over-limit case. A design that treats zero as unlimited shows up as extra writes, and one that fails to consume over-limit bytes shows up as a stalled handshake.
- Status flags set together, such as error with end of file, or overrun with end of file. A design with the priority reversed reports the end-of-file code where the error code belongs.
- Byte gaps just below the timeout, a stalling memory, an address that wraps, and a long busy period. These catch a timer that does not restart, data or address that changes while a write is stalled, and a result reported while the formatter is still busy.

// File: rtl/tpk_pkg.sv
package tpk_pkg;
    localparam int BYTE_W     = 8;
    localparam int FULL_BYTES = 4;
    localparam int TAIL_W     = 4;
    localparam int WORD_W     = FULL_BYTES * BYTE_W + TAIL_W;
    localparam int ACC_W      = FULL_BYTES * BYTE_W;
    localparam int IDX_W      = $clog2(FULL_BYTES + 1);

    localparam int ST_W    = 4;
    localparam int ST_BUSY = 0;
    localparam int ST_ERR  = 1;
    localparam int ST_OVR  = 2;
    localparam int ST_EOF  = 3;

    localparam int CODE_W = 6;
    localparam logic [CODE_W-1:0] CODE_EOF = 6'o60;
    localparam logic [CODE_W-1:0] CODE_ERR = 6'o50;

    typedef enum logic [1:0] {
        S_IDLE,
        S_RECV,
        S_WRITE,
        S_CHECK
    } ctl_state_e;
endpackage

// File: rtl/tpk_byte_rx.sv
module tpk_byte_rx
    import tpk_pkg::*;
#(
    parameter int TO_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              byte_rdy,
    input  logic [BYTE_W-1:0] byte_data_n,
    output logic              byte_ack,
    output logic              byte_stb,
    output logic [BYTE_W-1:0] byte_val,
    output logic              timeout
);
    localparam int TW = $clog2(TO_CYCLES + 1);

    typedef struct packed {
        logic              ack;
        logic              stb;
        logic              tout;
        logic [BYTE_W-1:0] data;
        logic [TW-1:0]     cnt;
    } rx_t;

    rx_t rx_d, rx_q;

    always_comb begin
        rx_d      = rx_q;
        rx_d.stb  = 1'b0;
        rx_d.tout = 1'b0;
        if (rx_q.ack) begin
            if (!byte_rdy) rx_d.ack = 1'b0;
        end else if (enable && !rx_q.tout) begin
            if (byte_rdy) begin
                rx_d.ack  = 1'b1;
                rx_d.stb  = 1'b1;
                rx_d.data = ~byte_data_n;
                rx_d.cnt  = '0;
            end else if (rx_q.cnt == TW'(TO_CYCLES - 1)) begin
                rx_d.tout = 1'b1;
                rx_d.cnt  = '0;
            end else begin
                rx_d.cnt = rx_q.cnt + 1'b1;
            end
        end else begin
            rx_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    assign byte_ack = rx_q.ack;
    assign byte_stb = rx_q.stb;
    assign byte_val = rx_q.data;
    assign timeout  = rx_q.tout;

    a_r3_ack_after_rdy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(byte_ack) |-> $past(byte_rdy));
    a_r3_ack_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_ack && byte_rdy) |=> byte_ack);
endmodule

// File: rtl/tpk_word_pack.sv
module tpk_word_pack
    import tpk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              byte_stb,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              word_full,
    output logic [WORD_W-1:0] word
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [IDX_W-1:0] idx;
    } pk_t;

    pk_t pk_d, pk_q;

    always_comb begin
        pk_d = pk_q;
        if (clear) begin
            pk_d.idx = '0;
        end else if (byte_stb) begin
            if (pk_q.idx == IDX_W'(FULL_BYTES)) begin
                pk_d.idx = '0;
            end else begin
                pk_d.acc = {pk_q.acc[ACC_W-BYTE_W-1:0], byte_in};
                pk_d.idx = pk_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end

    assign word_full = byte_stb && !clear && (pk_q.idx == IDX_W'(FULL_BYTES));
    assign word      = {pk_q.acc, byte_in[TAIL_W-1:0]};

    a_r6_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        pk_q.idx <= IDX_W'(FULL_BYTES));
endmodule

// File: rtl/tape_word_packer.sv
module tape_word_packer
    import tpk_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int CNT_W     = 18,
    parameter int TO_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [CNT_W-1:0]  word_limit,
    input  logic              byte_rdy,
    input  logic [BYTE_W-1:0] byte_data_n,
    output logic              byte_ack,
    input  logic [ST_W-1:0]   fmt_status_n,
    output logic              mem_wr_valid,
    input  logic              mem_wr_ready,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [WORD_W-1:0] mem_wr_data,
    output logic              done,
    output logic [WORD_W-1:0] result,
    output logic              too_long
);
    localparam int PAD_W = WORD_W - ADDR_W;

    typedef struct packed {
        ctl_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  remain;
        logic [WORD_W-1:0] wdata;
        logic              too_long;
        logic [WORD_W-1:0] result;
        logic              done;
    } ctl_t;

    ctl_t c_d, c_q;

    logic              rx_stb, rx_tout, pk_full;
    logic [BYTE_W-1:0] rx_byte;
    logic [WORD_W-1:0] pk_word;
    logic [ST_W-1:0]   stat;

    assign stat = ~fmt_status_n;

    tpk_byte_rx #(.TO_CYCLES(TO_CYCLES)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (c_q.state == S_RECV),
        .byte_rdy   (byte_rdy),
        .byte_data_n(byte_data_n),
        .byte_ack   (byte_ack),
        .byte_stb   (rx_stb),
        .byte_val   (rx_byte),
        .timeout    (rx_tout)
    );

    tpk_word_pack u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (c_q.state == S_IDLE),
        .byte_stb (rx_stb),
        .byte_in  (rx_byte),
        .word_full(pk_full),
        .word     (pk_word)
    );

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        unique case (c_q.state)
            S_IDLE: begin
                if (start) begin
                    c_d.addr     = base_addr;
                    c_d.remain   = word_limit;
                    c_d.too_long = 1'b0;
                    c_d.state    = S_RECV;
                end
            end
            S_RECV: begin
                if (pk_full) begin
                    if (c_q.remain != '0) begin
                        c_d.wdata = pk_word;
                        c_d.state = S_WRITE;
                    end else begin
                        c_d.too_long = 1'b1;
                    end
                end else if (rx_tout) begin
                    c_d.state = S_CHECK;
                end
            end
            S_WRITE: begin
                if (mem_wr_ready) begin
                    c_d.addr   = c_q.addr + 1'b1;
                    c_d.remain = c_q.remain - 1'b1;
                    c_d.state  = S_RECV;
                end
            end
            S_CHECK: begin
                if (!stat[ST_BUSY]) begin
                    if (stat[ST_ERR] || stat[ST_OVR])
                        c_d.result = {CODE_ERR, {(WORD_W-CODE_W){1'b0}}};
                    else if (stat[ST_EOF])
                        c_d.result = {CODE_EOF, {(WORD_W-CODE_W){1'b0}}};
                    else
                        c_d.result = {{PAD_W{1'b0}}, c_q.addr};
                    c_d.done  = 1'b1;
                    c_d.state = S_IDLE;
                end
            end
            default: c_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{state: S_IDLE, default: '0};
        else        c_q <= c_d;
    end

    assign mem_wr_valid = (c_q.state == S_WRITE);
    assign mem_wr_addr  = c_q.addr;
    assign mem_wr_data  = c_q.wdata;
    assign done         = c_q.done;
    assign result       = c_q.result;
    assign too_long     = c_q.too_long;

    a_r7_stall_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && !mem_wr_ready) |=>
            (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));
    a_r5_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> (c_q.remain != '0));
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r8_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !$past(stat[ST_BUSY]));
    a_r11_idle_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == S_IDLE && !byte_ack) |=> !$rose(byte_ack) || $past(start));
endmodule

// File: tb/tape_word_packer_test.sv
module tape_word_packer_test;
    localparam int TO = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] base_addr = '0;
    logic [17:0] word_limit = '0;
    logic        byte_rdy = 1'b0;
    logic [7:0]  byte_data_n = 8'hFF;
    logic        byte_ack;
    logic [3:0]  fmt_status_n = 4'hF;
    logic        mem_wr_valid;
    logic        mem_wr_ready = 1'b1;
    logic [23:0] mem_wr_addr;
    logic [35:0] mem_wr_data;
    logic        done;
    logic [35:0] result;
    logic        too_long;

    tape_word_packer #(.ADDR_W(24), .CNT_W(18), .TO_CYCLES(TO)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .word_limit(word_limit), .byte_rdy(byte_rdy), .byte_data_n(byte_data_n),
        .byte_ack(byte_ack), .fmt_status_n(fmt_status_n),
        .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .done(done), .result(result), .too_long(too_long)
    );

    always #4 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    logic slow = 1'b0;
    int rcnt = 0;
    always @(negedge clk) begin
        rcnt <= rcnt + 1;
        mem_wr_ready <= slow ? (rcnt % 3 == 0) : 1'b1;
    end

    logic [23:0] cap_a [0:255];
    logic [35:0] cap_d [0:255];
    int wr_n = 0;
    int done_n = 0;
    logic [35:0] got_res = '0;
    logic got_tl = 1'b0;
    always @(posedge clk) begin
        if (mem_wr_valid && mem_wr_ready && wr_n < 256) begin
            cap_a[wr_n] <= mem_wr_addr;
            cap_d[wr_n] <= mem_wr_data;
            wr_n <= wr_n + 1;
        end
        if (done) begin
            done_n <= done_n + 1;
            got_res <= result;
            got_tl <= too_long;
        end
    end

    typedef struct packed {
        logic [7:0] nb;
        logic [7:0] lim;
        logic [3:0] st;
        logic       slw;
        logic [7:0] ew;
        logic       tl;
    } vec_t;

    // st bits: 3 eof, 2 overrun, 1 error, 0 busy (true polarity)
    localparam vec_t VECS [0:8] = '{
        '{8'd10, 8'd4, 4'b0000, 1'b0, 8'd2, 1'b0},
        '{8'd13, 8'd4, 4'b0000, 1'b1, 8'd2, 1'b0},
        '{8'd15, 8'd2, 4'b1000, 1'b0, 8'd2, 1'b1},
        '{8'd5,  8'd1, 4'b0010, 1'b1, 8'd1, 1'b0},
        '{8'd7,  8'd3, 4'b0100, 1'b0, 8'd1, 1'b0},
        '{8'd0,  8'd3, 4'b0000, 1'b0, 8'd0, 1'b0},
        '{8'd20, 8'd0, 4'b0000, 1'b1, 8'd0, 1'b1},
        '{8'd5,  8'd5, 4'b1010, 1'b0, 8'd1, 1'b0},
        '{8'd10, 8'd9, 4'b1100, 1'b1, 8'd2, 1'b0}
    };

    function automatic logic [7:0] bval(int v, int j);
        int t;
        t = (v * 53 + j * 29 + 60) & 255;
        return t[7:0];
    endfunction

    function automatic logic [35:0] wexp(int v, int k);
        logic [7:0] b4;
        b4 = bval(v, 5 * k + 4);
        return {bval(v, 5 * k), bval(v, 5 * k + 1), bval(v, 5 * k + 2),
                bval(v, 5 * k + 3), b4[3:0]};
    endfunction

    function automatic logic [35:0] rexp(logic [3:0] st, logic [23:0] nxt);
        if (st[1] || st[2]) return {6'o50, 30'd0};
        if (st[3]) return {6'o60, 30'd0};
        return {12'd0, nxt};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [35:0] act,
                       input logic [35:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(posedge clk); #1;
        byte_rdy = 1'b1;
        byte_data_n = ~b;
        while (!byte_ack) begin @(posedge clk); #1; end
        byte_rdy = 1'b0;
        while (byte_ack) begin @(posedge clk); #1; end
    endtask

    task automatic run_rec(input int v, input logic [23:0] base,
                           input logic [17:0] lim, input int nb, input int gap);
        @(posedge clk); #1;
        start = 1'b1; base_addr = base; word_limit = lim;
        @(posedge clk); #1;
        start = 1'b0;
        for (int j = 0; j < nb; j++) begin
            repeat (gap) @(posedge clk);
            send_byte(bval(v, j));
        end
    endtask

    task automatic wait_done(input int prev);
        for (int i = 0; i < 3000 && done_n == prev; i++) @(posedge clk);
        #1;
    endtask

    task automatic check_words(input int v, input int first, input int ew,
                               input logic [23:0] base, input string req);
        chk(wr_n - first == ew, "R5 word count", 36'(wr_n - first), 36'(ew));
        for (int k = 0; k < ew && first + k < wr_n; k++) begin
            chk(cap_d[first + k] == wexp(v, k), {req, " R1 R2 data"},
                cap_d[first + k], wexp(v, k));
            chk(cap_a[first + k] == base + 24'(k), "R7 address",
                36'(cap_a[first + k]), 36'(base + 24'(k)));
        end
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R12: reset values
        chk(byte_ack == 0 && mem_wr_valid == 0 && done == 0, "R12 reset ctl",
            36'({byte_ack, mem_wr_valid, done}), 36'd0);
        chk(result == 0 && too_long == 0, "R12 reset result", result, 36'd0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;

        // R11: byte ready while idle is ignored
        byte_rdy = 1'b1; byte_data_n = 8'h00;
        begin
            int acks;
            acks = 0;
            for (int i = 0; i < 12; i++) begin @(posedge clk); #1; if (byte_ack) acks++; end
            chk(acks == 0 && wr_n == 0 && done_n == 0, "R11 idle ignore",
                36'(acks + wr_n + done_n), 36'd0);
        end
        byte_rdy = 1'b0;
        repeat (2) @(posedge clk);

        // table of records
        for (int v = 0; v < 9; v++) begin
            logic [23:0] base;
            int first, prev;
            base = (v == 8) ? 24'hFFFFFF : 24'(24'h001000 + v * 64);
            fmt_status_n = ~VECS[v].st;
            slow = VECS[v].slw;
            first = wr_n; prev = done_n;
            run_rec(v, base, 18'(VECS[v].lim), int'(VECS[v].nb), 0);
            wait_done(prev);
            chk(done_n == prev + 1, "R10 done", 36'(done_n - prev), 36'd1);
            chk(got_res == rexp(VECS[v].st, base + 24'(VECS[v].ew)), "R9 result",
                got_res, rexp(VECS[v].st, base + 24'(VECS[v].ew)));
            chk(got_tl == VECS[v].tl, "R5 too_long", 36'(got_tl), 36'(VECS[v].tl));
            check_words(v, first, int'(VECS[v].ew), base, "R6");
            repeat (3) @(posedge clk);
        end

        // R4: gaps just under the timeout keep the record open
        begin
            int first, prev;
            fmt_status_n = 4'hF; slow = 1'b0;
            first = wr_n; prev = done_n;
            run_rec(20, 24'h00ABC0, 18'd4, 10, TO - 10);
            chk(done_n == prev, "R4 no early end", 36'(done_n - prev), 36'd0);
            wait_done(prev);
            chk(got_res == {12'd0, 24'h00ABC2}, "R4 result", got_res, {12'd0, 24'h00ABC2});
            check_words(20, first, 2, 24'h00ABC0, "R4");
        end
        repeat (3) @(posedge clk);

        // R8: busy status delays the result
        begin
            int first, prev;
            fmt_status_n = ~4'b1001;
            first = wr_n; prev = done_n;
            run_rec(21, 24'h000200, 18'd2, 5, 0);
            repeat (TO + 40) @(posedge clk);
            #1;
            chk(done_n == prev, "R8 held while busy", 36'(done_n - prev), 36'd0);
            fmt_status_n = ~4'b1000;
            wait_done(prev);
            chk(done_n == prev + 1, "R8 done after idle", 36'(done_n - prev), 36'd1);
            chk(got_res == {6'o60, 30'd0}, "R8 R9 eof code", got_res, {6'o60, 30'd0});
            chk(got_tl == 1'b0, "R10 too_long cleared", 36'(got_tl), 36'd0);
            check_words(21, first, 1, 24'h000200, "R8");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule